// File: doc/BRIEF.md
# Bus Idle Cycle Inserter

This block is placed between a bus master's request port and the sequencer that runs accesses on an external memory bus. It holds back the next access for a configurable number of dead cycles so that the external bus can turn around. The number of dead cycles depends on how the previous granted access and the new request relate: a write followed by anything, a read followed by a write to another space, or a read followed by a write to the same space. A read followed by a read needs no gap.

Each of the address spaces has a small configuration word with three 2-bit gap codes, one per kind of transition. The codes of the space that the previous access used are the ones that apply, because the gap belongs to the tail of that access. A request is presented with a valid/ready handshake. An access is granted in every cycle in which valid and ready are both high, and `grant` reports this. Dead cycles in which no request was pending count toward the gap, so a request that arrives late may be granted at once.

Top module: `bus_gap_inserter`

## Requirements
- R1: A gap code maps to a dead-cycle count as 2'b00 to 0, 2'b01 to 1, 2'b10 to 2 and 2'b11 to 4.
- R2: After a granted write, the next access of either direction waits for the count of the write-follow code (bits 29:28) of the written space.
- R3: After a granted read, a write to a different space waits for the count of the other-space code (bits 26:25) of the read space.
- R4: After a granted read, a write to the same space waits for the count of the same-space code (bits 23:22) of that space.
- R5: Reset sets all three codes of every space to 2'b11, so a configuration word reads back as 32'h36C0_0000 and a gap of four cycles applies by default.
- R6: All configuration bits outside 29:28, 26:25 and 23:22 read back as 0 whatever was written to them.
- R7: A read that follows a granted read is ready at once.
- R8: The first request after reset is ready at once.
- R9: With g idle cycles (valid low) between a grant and the next request, and a required count N, the request sees exactly max(0, N - g) cycles with ready low, and `grant` is high in the cycle in which ready is first high while valid is high.
- R10: Space s is written and read at configuration index s (2-bit index, four spaces); the write port updates the word on the clock edge with the write enable high and the read port returns it combinationally.
- R11: A configuration write made while a gap is already counting down does not change that gap; it applies from the next gap on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until granted |
| req_write | input | 1 | Request direction, 1 = write |
| req_space | input | 2 | Space index of the request |
| req_ready | output | 1 | Request may be granted this cycle |
| grant | output | 1 | Access granted this cycle (valid and ready) |
| cfg_we | input | 1 | Configuration write enable |
| cfg_waddr | input | 2 | Space index for the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_raddr | input | 2 | Space index for the configuration read |
| cfg_rdata | output | 32 | Configuration word of the addressed space |

## Verification
Ready and grant are combinational on the request, so the bench drives a request on a falling edge and reads ready one time unit later. It then steps one falling edge per dead cycle, so the count of low-ready cycles equals the gap R9 predicts from the idle cycles it left before the request. Configuration writes land on the next rising edge and readback is combinational, so each readback is taken at the falling edge after the write. The mid-countdown write is placed one cycle after the request, once the countdown has already been loaded.

// File: rtl/gap_pkg.sv
package gap_pkg;
   localparam int FLD_W  = 2;
   localparam int WF_LO  = 28;
   localparam int DS_LO  = 25;
   localparam int SS_LO  = 22;
   localparam int IDLE_W = 3;
   localparam int CFG_W  = 3 * FLD_W;

   typedef struct packed {
      logic [FLD_W-1:0] wf;
      logic [FLD_W-1:0] ds;
      logic [FLD_W-1:0] ss;
   } gap_cfg_t;

   localparam gap_cfg_t CFG_RST = '{wf: 2'b11, ds: 2'b11, ss: 2'b11};

   typedef enum logic [1:0] {
      TR_NONE,
      TR_AFTER_WR,
      TR_RW_OTHER,
      TR_RW_SAME
   } trans_e;

   function automatic logic [IDLE_W-1:0] idle_decode(input logic [FLD_W-1:0] code);
      case (code)
         2'b00:   return 3'd0;
         2'b01:   return 3'd1;
         2'b10:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/gap_cfg_regs.sv
module gap_cfg_regs
   import gap_pkg::*;
#(
   parameter int NUM_SPACES = 4,
   parameter int SPACE_W    = 2,
   parameter int REG_W      = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [SPACE_W-1:0]          waddr,
   input  logic [REG_W-1:0]            wdata,
   input  logic [SPACE_W-1:0]          raddr,
   output logic [REG_W-1:0]            rdata,
   output logic [NUM_SPACES*CFG_W-1:0] cfg_flat
);
   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
      gap_cfg_t q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= CFG_RST;
         end else if (we && (waddr == SPACE_W'(s))) begin
            q <= {wdata[WF_LO +: FLD_W], wdata[DS_LO +: FLD_W], wdata[SS_LO +: FLD_W]};
         end
      end
      assign cfg_flat[s*CFG_W +: CFG_W] = q;
   end

   gap_cfg_t sel;
   always_comb begin
      sel   = cfg_flat[int'(raddr)*CFG_W +: CFG_W];
      rdata = '0;
      rdata[WF_LO +: FLD_W] = sel.wf;
      rdata[DS_LO +: FLD_W] = sel.ds;
      rdata[SS_LO +: FLD_W] = sel.ss;
   end
endmodule

// File: rtl/gap_classifier.sv
module gap_classifier
   import gap_pkg::*;
#(
   parameter int NUM_SPACES = 4,
   parameter int SPACE_W    = 2
) (
   input  logic                        prev_write,
   input  logic [SPACE_W-1:0]          prev_space,
   input  logic                        req_write,
   input  logic [SPACE_W-1:0]          req_space,
   input  logic [NUM_SPACES*CFG_W-1:0] cfg_flat,
   output logic [IDLE_W-1:0]           need
);
   gap_cfg_t pc;
   trans_e   kind;

   always_comb begin
      pc = cfg_flat[int'(prev_space)*CFG_W +: CFG_W];
      if (prev_write)
         kind = TR_AFTER_WR;
      else if (req_write)
         kind = (req_space == prev_space) ? TR_RW_SAME : TR_RW_OTHER;
      else
         kind = TR_NONE;

      case (kind)
         TR_AFTER_WR: need = idle_decode(pc.wf);
         TR_RW_OTHER: need = idle_decode(pc.ds);
         TR_RW_SAME:  need = idle_decode(pc.ss);
         default:     need = '0;
      endcase
   end
endmodule

// File: rtl/gap_timer.sv
module gap_timer
   import gap_pkg::*;
#(
   parameter int SPACE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [SPACE_W-1:0] req_space,
   input  logic [IDLE_W-1:0]  need,
   output logic               req_ready,
   output logic               grant,
   output logic               prev_write,
   output logic [SPACE_W-1:0] prev_space
);
   localparam logic [IDLE_W-1:0] SAT = IDLE_W'(4);

   logic              have_prev;
   logic              busy;
   logic [IDLE_W-1:0] elapsed;
   logic [IDLE_W-1:0] remain;

   always_comb begin
      if (busy)
         req_ready = (remain == '0);
      else
         req_ready = !have_prev || (need <= elapsed);
      grant = req_valid && req_ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_prev  <= 1'b0;
         prev_write <= 1'b0;
         prev_space <= '0;
         elapsed    <= SAT;
         busy       <= 1'b0;
         remain     <= '0;
      end else if (grant) begin
         have_prev  <= 1'b1;
         prev_write <= req_write;
         prev_space <= req_space;
         elapsed    <= '0;
         busy       <= 1'b0;
         remain     <= '0;
      end else begin
         if (elapsed != SAT)
            elapsed <= elapsed + 1'b1;
         if (busy) begin
            if (remain != '0)
               remain <= remain - 1'b1;
         end else if (req_valid) begin
            busy   <= 1'b1;
            remain <= need - elapsed - 1'b1;
         end
      end
   end
endmodule

// File: rtl/bus_gap_inserter.sv
module bus_gap_inserter
   import gap_pkg::*;
#(
   parameter int NUM_SPACES = 4,
   parameter int REG_W      = 32,
   parameter int SPACE_W    = $clog2(NUM_SPACES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [SPACE_W-1:0] req_space,
   output logic               req_ready,
   output logic               grant,
   input  logic               cfg_we,
   input  logic [SPACE_W-1:0] cfg_waddr,
   input  logic [REG_W-1:0]   cfg_wdata,
   input  logic [SPACE_W-1:0] cfg_raddr,
   output logic [REG_W-1:0]   cfg_rdata
);
   if (NUM_SPACES < 2 || (NUM_SPACES & (NUM_SPACES - 1)) != 0) begin : g_bad_spaces
      $error("NUM_SPACES must be a power of two of at least 2");
   end
   if (REG_W < WF_LO + FLD_W) begin : g_bad_width
      $error("REG_W too narrow for the gap code fields");
   end
   if (SPACE_W != $clog2(NUM_SPACES)) begin : g_bad_index
      $error("SPACE_W must match NUM_SPACES");
   end

   logic [NUM_SPACES*CFG_W-1:0] cfg_flat;
   logic                        prev_write;
   logic [SPACE_W-1:0]          prev_space;
   logic [IDLE_W-1:0]           need;

   gap_cfg_regs #(
      .NUM_SPACES(NUM_SPACES),
      .SPACE_W   (SPACE_W),
      .REG_W     (REG_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .waddr   (cfg_waddr),
      .wdata   (cfg_wdata),
      .raddr   (cfg_raddr),
      .rdata   (cfg_rdata),
      .cfg_flat(cfg_flat)
   );

   gap_classifier #(
      .NUM_SPACES(NUM_SPACES),
      .SPACE_W   (SPACE_W)
   ) u_class (
      .prev_write(prev_write),
      .prev_space(prev_space),
      .req_write (req_write),
      .req_space (req_space),
      .cfg_flat  (cfg_flat),
      .need      (need)
   );

   gap_timer #(
      .SPACE_W(SPACE_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_space (req_space),
      .need      (need),
      .req_ready (req_ready),
      .grant     (grant),
      .prev_write(prev_write),
      .prev_space(prev_space)
   );
endmodule

// File: rtl/bus_gap_inserter_chk.sv
module bus_gap_inserter_chk
   import gap_pkg::*;
#(
   parameter int NUM_SPACES = 4,
   parameter int REG_W      = 32,
   parameter int SPACE_W    = $clog2(NUM_SPACES)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        req_valid,
   input logic                        req_write,
   input logic [SPACE_W-1:0]          req_space,
   input logic                        req_ready,
   input logic                        grant,
   input logic [REG_W-1:0]            cfg_rdata,
   input logic [NUM_SPACES*CFG_W-1:0] cfg_q
);
   localparam logic [REG_W-1:0] MASK = (REG_W'(3) << WF_LO) | (REG_W'(3) << DS_LO) |
                                       (REG_W'(3) << SS_LO);

   logic               seen;
   logic               last_write;
   logic [SPACE_W-1:0] last_space;
   logic [2:0]         gap_c;
   logic               pend;
   logic [IDLE_W-1:0]  need_lock;
   logic [IDLE_W-1:0]  need_now;
   logic [IDLE_W-1:0]  need_use;
   gap_cfg_t           lc;

   always_comb begin
      lc = cfg_q[int'(last_space)*CFG_W +: CFG_W];
      if (last_write)
         need_now = idle_decode(lc.wf);
      else if (req_write && req_space == last_space)
         need_now = idle_decode(lc.ss);
      else if (req_write)
         need_now = idle_decode(lc.ds);
      else
         need_now = '0;
      need_use = pend ? need_lock : need_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen       <= 1'b0;
         last_write <= 1'b0;
         last_space <= '0;
         gap_c      <= '0;
         pend       <= 1'b0;
         need_lock  <= '0;
      end else if (grant) begin
         seen       <= 1'b1;
         last_write <= req_write;
         last_space <= req_space;
         gap_c      <= '0;
         pend       <= 1'b0;
      end else begin
         if (gap_c != 3'd7)
            gap_c <= gap_c + 1'b1;
         if (req_valid && !pend) begin
            pend      <= 1'b1;
            need_lock <= need_now;
         end
      end
   end

   // R2, R3, R4, R11: a grant never comes before the locked gap has passed
   assert_min_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && seen) |-> (gap_c >= 3'(need_use)));

   // R9: once the gap has passed, a pending request is ready
   assert_no_extra_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && seen && gap_c >= 3'(need_use)) |-> req_ready);

   assert_first_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !seen) |-> req_ready);

   assert_rdrd_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && seen && !last_write && !req_write) |-> req_ready);

   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_rdata & ~MASK) == '0));
endmodule

bind bus_gap_inserter bus_gap_inserter_chk #(
   .NUM_SPACES(NUM_SPACES),
   .REG_W     (REG_W),
   .SPACE_W   (SPACE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .req_space(req_space),
   .req_ready(req_ready),
   .grant    (grant),
   .cfg_rdata(cfg_rdata),
   .cfg_q    (cfg_flat)
);

// File: tb/test_bus_gap_inserter.sv
module test_bus_gap_inserter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_space = '0;
   logic        req_ready;
   logic        grant;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_waddr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [1:0]  cfg_raddr = '0;
   logic [31:0] cfg_rdata;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   bus_gap_inserter i_bus_gap_inserter (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .req_space(req_space),
      .req_ready(req_ready),
      .grant    (grant),
      .cfg_we   (cfg_we),
      .cfg_waddr(cfg_waddr),
      .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr),
      .cfg_rdata(cfg_rdata)
   );

   // Vector table: idle cycles before request, direction, space, expected wait.
   // Config: space0 codes wf=01 ds=10 ss=11; space1 wf=10 ds=00 ss=01; spaces 2,3 reset.
   localparam int NV = 14;
   localparam int V_GAP [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 2, 0, 5, 0, 0};
   localparam bit V_WR  [NV] = '{0, 0, 1, 1, 0, 1, 0, 1, 1, 0, 1, 1, 0, 1};
   localparam int V_SP  [NV] = '{0, 1, 1, 0, 0, 1, 1, 2, 2, 3, 0, 0, 0, 0};
   localparam int V_EXP [NV] = '{0, 0, 1, 2, 1, 2, 1, 0, 4, 2, 4, 0, 1, 4};
   localparam string V_REQ [NV] = '{"R8", "R7", "R4", "R2", "R2", "R3", "R9", "R3",
                                    "R5", "R9", "R3", "R9", "R1", "R4"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] sp, input logic [31:0] data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_waddr = sp;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic cfg_check(input logic [1:0] sp, input logic [31:0] exp, input string req);
      cfg_raddr = sp;
      #1;
      check(req, cfg_rdata, exp);
   endtask

   // Starts and ends at a falling edge; the next call may request at once.
   task automatic access(input int gap, input bit wr, input logic [1:0] sp,
                         input int exp_wait, input string req, input bit zero_cfg_mid);
      int waited = 0;
      repeat (gap) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_space = sp;
      #1;
      while (!req_ready && waited < 20) begin
         @(negedge clk);
         cfg_we = 1'b0;
         if (zero_cfg_mid && waited == 0) begin
            cfg_we    = 1'b1;
            cfg_waddr = sp;
            cfg_wdata = 32'h0;
         end
         #1;
         waited++;
      end
      check(req, 32'(waited), 32'(exp_wait));
      check("R9", {31'b0, grant}, 32'd1);
      @(negedge clk);
      cfg_we    = 1'b0;
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int s = 0; s < 4; s++) cfg_check(2'(s), 32'h36C0_0000, "R5");
      check("R8", {31'b0, req_ready}, 32'd1);

      cfg_write(2'd0, 32'h14C0_0000);
      cfg_check(2'd0, 32'h14C0_0000, "R10");
      cfg_write(2'd1, 32'h2040_0000);
      cfg_check(2'd1, 32'h2040_0000, "R10");
      cfg_write(2'd3, 32'hFFFF_FFFF);
      cfg_check(2'd3, 32'h36C0_0000, "R6");

      for (int i = 0; i < NV; i++)
         access(V_GAP[i], V_WR[i], 2'(V_SP[i]), V_EXP[i], V_REQ[i], 1'b0);

      // R11: write clearing space0 lands during a four-cycle countdown
      cfg_write(2'd0, 32'h36C0_0000);
      access(5, 1'b0, 2'd0, 0, "R2", 1'b0);
      access(0, 1'b1, 2'd0, 4, "R11", 1'b1);
      cfg_check(2'd0, 32'h0, "R11");
      access(0, 1'b0, 2'd0, 0, "R11", 1'b0);
      access(0, 1'b0, 2'd1, 0, "R7", 1'b0);

      // Reset in mid-run restores the default codes
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cfg_check(2'd0, 32'h36C0_0000, "R5");
      access(0, 1'b1, 2'd0, 0, "R8", 1'b0);
      access(0, 1'b1, 2'd0, 4, "R5", 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule